// File: doc/BRIEF.md
# Interval Timer with Toggle Output

This block is one channel of an 8-bit interval timer. An up counter advances by one on each cycle in which an external count-enable strobe (`tick`) is high. It is held at zero while the channel is stopped. On a tick where the counter already equals the programmed compare value, the counter returns to zero and a one-cycle interrupt pulse is raised. The repeat interval is therefore compare value + 1 ticks.

A single output flip-flop can flip on every match when match toggling is enabled. Software can also drive it through a 2-bit command field carried in each control write: force it high, force it low, invert it, or leave it alone. A registered pin multiplexer places either the flip-flop or ordinary port data on the shared output pin, depending on a function-select bit.

Both registers are written over a one-word bus with a single address bit. Address 0 holds the compare value. Address 1 is the control word.

Top module: `interval_timer_tog`

## Requirements
- R1: After reset `irq` is 0, the counter is 0, the channel is stopped, match toggling and pin select are off, and the flip-flop is 0. From the second cycle after reset `tmr_pin` follows `port_dout`.
- R2: While running, each cycle with `tick` high advances the counter by one. If the counter already equals the compare value on such a cycle, the counter goes to 0 instead. Cycles without `tick` leave the counter unchanged, so a match occurs every compare value + 1 ticks.
- R3: `irq` is high for exactly the cycle after the edge on which a match clears the counter, and is 0 otherwise.
- R4: With a compare value of 0, every tick is a match and raises `irq`.
- R5: Control bit 0 (run) = 0 holds the counter at 0 and suppresses matches. After run is set again, the first match needs a full compare value + 1 ticks.
- R6: With control bit 1 (toggle enable) = 1, each match inverts the flip-flop.
- R7: With toggle enable = 0, matches still raise `irq` but leave the flip-flop unchanged.
- R8: A control write with bits [3:2] = 01 sets the flip-flop to 1. Bits [3:2] = 10 clear it to 0.
- R9: A control write with bits [3:2] = 00 inverts the flip-flop.
- R10: A control write with bits [3:2] = 11 leaves the flip-flop unchanged, while still updating run, toggle enable and pin select.
- R11: When a software command and a match toggle fall on the same cycle, only the software command is applied.
- R12: `tmr_pin` is registered. One cycle after the sampling edge it carries the flip-flop value when control bit 4 (pin select) is 1, and `port_dout` otherwise.
- R13: A write with `wr_sel` = 0 loads the compare value from `wr_data`. A write with `wr_sel` = 1 loads the control word. Both take effect on the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 compare, 1 control |
| wr_data | input | DW (8) | Write data |
| port_dout | input | 1 | Ordinary port data for the shared pin |
| irq | output | 1 | One-cycle match interrupt |
| tmr_pin | output | 1 | Shared output pin |

## Verification
Results arrive at fixed latencies:
- `irq` and the flip-flop change on the same edge that samples a tick or a write.
- `tmr_pin` shows a flip-flop change one edge later.

The bench drives `tick` and writes between edges and reads `irq` at the falling edge right after the sampling edge. It reads `tmr_pin` only after one further idle cycle, and checks that `irq` has dropped in that idle cycle. Coincidence cases combine a tick and a control write in the same cycle so that both hit the same edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    CMD_INV = 2'b00,
    CMD_SET = 2'b01,
    CMD_CLR = 2'b10,
    CMD_NOP = 2'b11
  } tff_cmd_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_TEN  = 1;
  localparam int CTL_CMD  = 2;
  localparam int CTL_SEL  = 4;
  localparam int CTL_BITS = 5;

  typedef struct packed {
    logic pin_sel;
    logic tog_en;
    logic run;
  } ctl_t;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [CNT_W-1:0] cmp_q,
  output ctl_t             ctl_q,
  output logic             cmd_vld,
  output tff_cmd_e         cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) begin
        ctl_q.run     <= wr_data[CTL_RUN];
        ctl_q.tog_en  <= wr_data[CTL_TEN];
        ctl_q.pin_sel <= wr_data[CTL_SEL];
      end else begin
        cmp_q <= wr_data[CNT_W-1:0];
      end
    end
  end

  // command strobe is applied by the flip-flop on the write edge itself
  assign cmd_vld = wr_en & wr_sel;
  assign cmd     = tff_cmd_e'(wr_data[CTL_CMD+1:CTL_CMD]);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic             match,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;

  assign match = run & tick & (cnt_q == cmp);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= match;
      if (match)     cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  match_clear_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt_q == '0) && irq);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
  // R5
  stop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0) && !irq);
  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(match));
endmodule

// File: rtl/itmr_flop.sv
module itmr_flop
  import itmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_vld,
  input  tff_cmd_e cmd,
  input  logic     match,
  input  logic     tog_en,
  output logic     tff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tff <= 1'b0;
    end else if (cmd_vld && cmd != CMD_NOP) begin
      case (cmd)
        CMD_SET: tff <= 1'b1;
        CMD_CLR: tff <= 1'b0;
        default: tff <= ~tff;
      endcase
    end else if (match && tog_en) begin
      tff <= ~tff;
    end
  end

  // R8
  sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_SET) |=> tff);
  // R8
  sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_CLR) |=> !tff);
  // R11
  sw_inv_once_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_INV) |=> tff != $past(tff));
  // R10
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_NOP && !(match && tog_en)) |=> $stable(tff));
  // R7
  no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_vld && !tog_en) |=> $stable(tff));
  // R6
  match_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_vld && match && tog_en) |=> tff != $past(tff));
endmodule

// File: rtl/interval_timer_tog.sv
module interval_timer_tog
  import itmr_pkg::*;
#(
  parameter  int CNT_W = 8,
  localparam int DW    = (CNT_W > CTL_BITS) ? CNT_W : CTL_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          port_dout,
  output logic          irq,
  output logic          tmr_pin
);
  logic [CNT_W-1:0] cmp_q;
  ctl_t             ctl_q;
  logic             cmd_vld;
  tff_cmd_e         cmd;
  logic             match;
  logic             tff;

  itmr_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_q(cmp_q), .ctl_q(ctl_q), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl_q.run), .tick(tick), .cmp(cmp_q),
    .match(match), .irq(irq)
  );

  itmr_flop u_tff (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd(cmd), .match(match),
    .tog_en(ctl_q.tog_en), .tff(tff)
  );

  always_ff @(posedge clk) begin
    if (rst) tmr_pin <= 1'b0;
    else     tmr_pin <= ctl_q.pin_sel ? tff : port_dout;
  end

  // R12
  pin_mux_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tmr_pin == $past(ctl_q.pin_sel ? tff : port_dout));
endmodule

// File: tb/sim_interval_timer_tog.sv
module sim_interval_timer_tog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       port_dout = 1'b1;
  logic       irq;
  logic       tmr_pin;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  interval_timer_tog #(.CNT_W(8)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .port_dout(port_dout), .irq(irq), .tmr_pin(tmr_pin)
  );

  function automatic logic [7:0] ctl(bit run, bit ten, logic [1:0] c, bit sel);
    return {3'b000, sel, c, ten, run};
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(logic exp_irq, string tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(tag, irq, exp_irq);
  endtask

  task automatic ticks_quiet(int n, string tag);
    for (int i = 0; i < n; i++) do_tick(1'b0, tag);
  endtask

  // one idle cycle, then the pin shows the flip-flop state of the last edge
  task automatic check_pin(logic exp, string tag);
    @(negedge clk);
    chk({tag, " pin"}, tmr_pin, exp);
    chk("R3 irq drops when idle", irq, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 pin follows port", tmr_pin, 1'b1);
  endtask

  task automatic t_sw_cmds;
    wr(1, ctl(0, 0, 2'b10, 1)); check_pin(1'b0, "R8 clear");
    wr(1, ctl(0, 0, 2'b01, 1)); check_pin(1'b1, "R8 set");
    wr(1, ctl(0, 0, 2'b00, 1)); check_pin(1'b0, "R9 invert 1->0");
    wr(1, ctl(0, 0, 2'b00, 1)); check_pin(1'b1, "R9 invert 0->1");
    wr(1, ctl(0, 0, 2'b11, 1)); check_pin(1'b1, "R10 nop keeps 1");
    wr(1, ctl(0, 0, 2'b10, 1));
    wr(1, ctl(0, 0, 2'b11, 1)); check_pin(1'b0, "R10 nop keeps 0");
  endtask

  task automatic t_pin_mux;
    wr(1, ctl(0, 0, 2'b11, 0)); check_pin(1'b1, "R12 port data 1");
    port_dout = 1'b0;           check_pin(1'b0, "R12 port data 0");
    port_dout = 1'b1;
    wr(1, ctl(0, 0, 2'b11, 1)); check_pin(1'b0, "R12 timer select");
  endtask

  task automatic t_interval;
    wr(0, 8'd3);
    wr(1, ctl(1, 1, 2'b11, 1));
    ticks_quiet(3, "R2 no match before 4th tick");
    do_tick(1'b1, "R2 match on 4th tick");
    check_pin(1'b1, "R6 toggle on match");
    ticks_quiet(2, "R2 counting after clear");
    @(negedge clk);
    chk("R2 no irq without tick", irq, 1'b0);
    ticks_quiet(1, "R2 third tick of period");
    do_tick(1'b1, "R2 second period");
    check_pin(1'b0, "R6 toggle back");
  endtask

  task automatic t_no_toggle;
    wr(1, ctl(1, 0, 2'b11, 1));
    ticks_quiet(3, "R7 counting");
    do_tick(1'b1, "R7 irq still raised");
    check_pin(1'b0, "R7 flip-flop unchanged");
  endtask

  task automatic t_stop;
    wr(1, ctl(1, 1, 2'b11, 1));
    ticks_quiet(2, "R5 partial count");
    wr(1, ctl(0, 1, 2'b11, 1));
    ticks_quiet(5, "R5 stopped ignores ticks");
    wr(1, ctl(1, 1, 2'b11, 1));
    ticks_quiet(3, "R5 restart from zero");
    do_tick(1'b1, "R5 full period after restart");
    check_pin(1'b1, "R5 toggle after restart");
  endtask

  task automatic t_zero;
    wr(0, 8'd0);
    do_tick(1'b1, "R4 cmp0 tick 1");
    do_tick(1'b1, "R4 cmp0 tick 2");
    do_tick(1'b1, "R4 cmp0 tick 3");
    check_pin(1'b0, "R4 three toggles");
  endtask

  task automatic t_prio;
    wr(0, 8'd3);
    ticks_quiet(3, "R11 approach match");
    tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = ctl(1, 1, 2'b10, 1);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R11 irq with clear cmd", irq, 1'b1);
    check_pin(1'b0, "R11 clear wins over toggle");
    ticks_quiet(3, "R11 approach second match");
    tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = ctl(1, 1, 2'b00, 1);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R11 irq with invert cmd", irq, 1'b1);
    check_pin(1'b1, "R11 single inversion");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sw_cmds();   // R13 control word path
    t_pin_mux();
    t_interval();  // R13 compare path
    t_no_toggle();
    t_stop();
    t_zero();
    t_prio();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule